// File: doc/BRIEF.md
# Iterative Unsigned Integer Divider

This block divides one unsigned integer by another over several clock cycles and works out one quotient bit in each cycle. A partial-remainder register starts at zero. A second register starts out holding the dividend, and quotient bits move into it from the bottom. In every step the two registers are shifted left together as one word. The stored divisor is then trial-subtracted from the widened partial remainder. When the divisor fits, the difference is kept and a one enters the quotient. When it does not fit, the shifted value is kept and a zero enters.

A caller raises `start` for one cycle with both operands. `busy` stays high while the steps run. The cycle that `done` is high, the quotient and remainder can be read, and both keep their values until the next accepted start. A zero divisor skips the steps. The divider then answers in one cycle with a flag, an all-ones quotient and the dividend returned as the remainder.

Top module: `udiv_iter`

## Requirements
- R1: After reset, `busy`, `done` and `div_zero` are 0, and `quotient` and `remainder` are 0.
- R2: A `start` taken while idle with a nonzero divisor makes `busy` high from the next cycle until the result is delivered.
- R3: With a nonzero divisor, `done` rises exactly WIDTH clock edges after the edge that took `start`. It is high for one cycle only, and `busy` is low in that cycle.
- R4: At `done`, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor, both unsigned.
- R5: The partial remainder is always less than the stored divisor while the steps run, and the final remainder is less than the divisor.
- R6: A zero divisor makes `done` rise on the edge that takes `start`, with `quotient` all ones, `remainder` equal to the dividend and `div_zero` = 1.
- R7: `div_zero` is 0 for any result produced with a nonzero divisor.
- R8: A `start` pulse or a change of the operand inputs while `busy` is high is ignored. The result and the timing of `done` are those of the operation already running.
- R9: `quotient`, `remainder` and `div_zero` keep their values after `done` until the next accepted `start`.
- R10: Extreme operands lose no bits. An all-ones dividend divided by 1 gives an all-ones quotient and a remainder of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division (taken only while idle) |
| dividend | input | WIDTH | Number to be divided |
| divisor | input | WIDTH | Number to divide by |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse: result is ready |
| quotient | output | WIDTH | Quotient (all ones on a zero divisor) |
| remainder | output | WIDTH | Remainder (the dividend on a zero divisor) |
| div_zero | output | 1 | Last result came from a zero divisor |

## Verification
With a nonzero divisor the result is due exactly WIDTH edges after the edge that takes `start`. With a zero divisor it is due on that same edge. The bench drives inputs and samples outputs on falling edges and counts rising edges from the start edge up to the first sample showing `done`. That count must equal the expected latency before the quotient and remainder are compared with the bench's own division. One sample later the bench confirms that `done` has fallen. It also confirms that the outputs stay unchanged over several idle cycles and during a start that is poked in mid-run.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/udiv_step.sv
// One shift-and-trial-subtract step of the restoring division.
module udiv_step #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] quo,
  input  logic [WIDTH-1:0] dvsr,
  output logic [WIDTH-1:0] acc_nx,
  output logic [WIDTH-1:0] quo_nx,
  output logic             fits
);
  localparam int WW = WIDTH + 1;

  // Partial remainder after the shift; one extra bit so no carry is lost.
  function automatic logic [WW-1:0] shift_in(input logic [WIDTH-1:0] a,
                                             input logic              b);
    return {a, b};
  endfunction

  function automatic logic divisor_fits(input logic [WW-1:0] pr,
                                        input logic [WIDTH-1:0] d);
    return pr >= {1'b0, d};
  endfunction

  logic [WW-1:0] wide;
  logic [WW-1:0] diff;

  always_comb begin
    wide   = shift_in(acc, quo[WIDTH-1]);
    diff   = wide - {1'b0, dvsr};
    fits   = divisor_fits(wide, dvsr);
    acc_nx = fits ? diff[WIDTH-1:0] : wide[WIDTH-1:0];
    quo_nx = {quo[WIDTH-2:0], fits};
  end
endmodule

// File: rtl/udiv_seq.sv
// Sequencer: accepts start, counts WIDTH steps, flags the last one.
module udiv_seq
  import udiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dvsr_is_zero,
  output logic load_go,
  output logic zero_go,
  output logic step_en,
  output logic last_step,
  output logic busy
);
  localparam int CW = $clog2(WIDTH + 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;

  always_comb begin
    load_go   = (state == SEQ_IDLE) && start && !dvsr_is_zero;
    zero_go   = (state == SEQ_IDLE) && start &&  dvsr_is_zero;
    step_en   = (state == SEQ_RUN);
    last_step = step_en && (cnt == CW'(1));
    busy      = (state == SEQ_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else if (load_go) begin
      state <= SEQ_RUN;
      cnt   <= CW'(WIDTH);
    end else if (step_en) begin
      cnt <= cnt - CW'(1);
      if (last_step) state <= SEQ_IDLE;
    end
  end

  // R3: one step per cycle, counter never wraps while running
  assert_step_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !last_step |=> step_en && (cnt == $past(cnt) - CW'(1)));
  assert_run_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> !busy);
  // R8: a start while running is not taken
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load_go && !zero_go);
endmodule

// File: rtl/udiv_iter.sv
// Iterative restoring divider for unsigned operands.
module udiv_iter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_zero
);
  logic [WIDTH-1:0] acc_q, quo_q, dvsr_q;
  logic [WIDTH-1:0] acc_nx, quo_nx;
  logic             fits;
  logic             load_go, zero_go, step_en, last_step;
  logic             done_q, dz_q;

  udiv_seq #(.WIDTH(WIDTH)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dvsr_is_zero(divisor == '0),
    .load_go     (load_go),
    .zero_go     (zero_go),
    .step_en     (step_en),
    .last_step   (last_step),
    .busy        (busy)
  );

  udiv_step #(.WIDTH(WIDTH)) step_i (
    .acc   (acc_q),
    .quo   (quo_q),
    .dvsr  (dvsr_q),
    .acc_nx(acc_nx),
    .quo_nx(quo_nx),
    .fits  (fits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      quo_q  <= '0;
      dvsr_q <= '0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else if (zero_go) begin
      acc_q  <= dividend;
      quo_q  <= '1;
      dvsr_q <= '0;
      done_q <= 1'b1;
      dz_q   <= 1'b1;
    end else if (load_go) begin
      acc_q  <= '0;
      quo_q  <= dividend;
      dvsr_q <= divisor;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else if (step_en) begin
      acc_q  <= acc_nx;
      quo_q  <= quo_nx;
      done_q <= last_step;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = acc_q;
  assign div_zero  = dz_q;

  // R3: done is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: partial remainder stays below the divisor during the steps
  assert_partial_lt_dvsr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> acc_q < dvsr_q);
  assert_final_lt_dvsr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !div_zero |-> remainder < dvsr_q);
  // R6: zero divisor gives an all-ones quotient
  assert_zero_quot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && div_zero |-> quotient == '1);
  // R8: stored divisor cannot change while running
  assert_dvsr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(dvsr_q));
  // R9: results hold while idle with no start
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start && !done |=> $stable(quotient) && $stable(remainder) && $stable(div_zero));
endmodule

// File: tb/udiv_iter_tb.sv
module udiv_iter_tb_top;
  localparam int WIDTH = 16;
  localparam logic [WIDTH-1:0] ONES = '1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [WIDTH-1:0] dividend = '0, divisor = '0;
  logic             busy, done, div_zero;
  logic [WIDTH-1:0] quotient, remainder;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  udiv_iter #(.WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
  );

  function automatic logic [WIDTH-1:0] ref_q(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    return (b == 0) ? ONES : a / b;
  endfunction
  function automatic logic [WIDTH-1:0] ref_r(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    return (b == 0) ? a : a % b;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One division; poke=1 raises a junk start while busy (R8).
  task automatic run_op(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b, input bit poke);
    int lat;
    int exp_lat;
    logic [WIDTH-1:0] hq, hr;
    exp_lat = (b == 0) ? 0 : WIDTH;
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (b != 0) check(busy === 1'b1, "R2", "busy after start", busy, 1);
    lat = 0;
    while (done !== 1'b1 && lat < WIDTH + 4) begin
      if (poke && lat == 2) begin
        start = 1'b1; dividend = ~a; divisor = b ^ 16'h0005;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(lat == exp_lat, (b == 0) ? "R6" : (poke ? "R8" : "R3"), "done latency", lat, exp_lat);
    check(busy === 1'b0, "R3", "busy low at done", busy, 0);
    check(quotient === ref_q(a, b), (b == 0) ? "R6" : (poke ? "R8" : "R4"), "quotient", quotient, ref_q(a, b));
    check(remainder === ref_r(a, b), (b == 0) ? "R6" : (poke ? "R8" : "R4"), "remainder", remainder, ref_r(a, b));
    check(div_zero === (b == 0), (b == 0) ? "R6" : "R7", "div_zero", div_zero, (b == 0));
    if (b != 0) check(remainder < b, "R5", "remainder below divisor", remainder, b);
    hq = quotient; hr = remainder;
    @(negedge clk);
    check(done === 1'b0, "R3", "done one cycle", done, 0);
    dividend = ~dividend; divisor = divisor + 16'd3;
    repeat (2) @(negedge clk);
    check(quotient === hq && remainder === hr, "R9", "outputs held", {quotient, remainder}, {hq, hr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] a, b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 0 && done === 0 && div_zero === 0, "R1", "reset flags", {busy, done, div_zero}, 0);
    check(quotient === 0 && remainder === 0, "R1", "reset data", {quotient, remainder}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    run_op(16'd100, 16'd7, 1'b0);
    run_op(ONES, 16'd1, 1'b0);          // R10
    run_op(ONES, ONES, 1'b0);           // R10
    run_op(16'd5, 16'd9, 1'b0);         // divisor larger
    run_op(16'd0, 16'd3, 1'b0);
    run_op(16'h1234, 16'd0, 1'b0);      // R6
    run_op(16'h8000, 16'h8001, 1'b0);
    run_op(16'hBEEF, 16'd13, 1'b1);     // R8
    run_op(16'h0, 16'h0, 1'b0);         // R6
    run_op(16'hFFFE, 16'h7FFF, 1'b1);   // R8
    // random
    for (int i = 0; i < 60; i++) begin
      a = WIDTH'($urandom);
      case ($urandom % 4)
        0: b = WIDTH'($urandom % 16);
        1: b = WIDTH'($urandom % 256);
        default: b = WIDTH'($urandom);
      endcase
      run_op(a, b, (i % 7) == 3);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule